// File: doc/BRIEF.md
# Tagged Micro-Word Transport Packet Reassembler

This block accepts a stream of 32-bit micro-words in which up to four transport streams are interleaved. Each word carries a 3-bit tag naming its stream, a packet-start flag, a device overflow flag, a 3-bit rolling sequence count and three payload bytes. The block keeps separate reassembly state for each stream. It rebuilds 188-byte transport packets, where 63 words form one packet and the final word of a packet supplies only two bytes.

Rebuilt bytes leave one per cycle on a byte bus. Each byte carries its stream number, a flag on the first byte of a packet and a flag on the last byte. For each stream there is also a one-cycle pulse for a sequence gap and one for a reported device overflow. The input has no backpressure. The source spaces its words so that the serializer can drain every word before the next one arrives.

Top module: `mpkt_reasm`

## Requirements
- R1: While reset is held and in the first cycle after it, `outValid`, `outStart`, `outEnd`, `lossPulse` and `ovflPulse` are all zero.
- R2: Tag field bits 31:29 hold the stream number plus one, so tag 1 selects stream 0 and tag 4 selects stream 3. A word tagged 0 or 5 to 7 produces no byte and no pulse, and changes no stream's state.
- R3: When start flag bit 25 is set, the stream's word position becomes zero before the word is used. The word's first byte then carries `outStart`, even in the middle of a packet.
- R4: A word whose stream is at word position zero and whose start flag is clear is discarded. It yields no byte and no pulse, and it does not change that stream's sequence reference.
- R5: Bits 28:26 are a sequence count. An accepted word whose count is not the stream's stored count plus one (modulo 8) raises `lossPulse[stream]` for one cycle, in the same cycle as that word's first byte. The first word a stream accepts after reset is never checked. Every accepted word stores its count as the new reference.
- R6: An accepted word with bit 24 set raises `ovflPulse[stream]` for one cycle, in the same cycle as its first byte.
- R7: An accepted word's bytes appear on consecutive cycles in the order bits 23:16, 15:8, 7:0. The first byte appears in the cycle after the word is sampled, and every byte carries its stream number on `outStream`.
- R8: Words 1 to 63 of a packet give exactly 188 bytes. The 63rd word gives bits 23:16 and 15:8 only, with its low byte dropped. `outStart` marks byte 0 and `outEnd` marks byte 187.
- R9: After the 63rd word the stream's word position returns to zero. The next word for that stream must therefore carry the start flag, or it is discarded under R4.
- R10: Each stream keeps its own word position, sequence reference and reference-valid state. Words of different streams may interleave in any order without affecting each other.
- R11: Two accepted words may be sampled with as few as two idle cycles between them. All bytes of both words are then delivered intact.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| inValid | input | 1 | Micro-word present this cycle |
| inWord | input | 32 | Tagged micro-word |
| outValid | output | 1 | Output byte valid |
| outByte | output | 8 | Reassembled payload byte |
| outStart | output | 1 | First byte of a packet |
| outEnd | output | 1 | Last byte (byte 187) of a packet |
| outStream | output | 2 | Stream number of the output byte |
| lossPulse | output | 4 | Per-stream sequence gap pulse |
| ovflPulse | output | 4 | Per-stream device overflow pulse |

## Verification
A complete 63-word packet with distinct byte values in every lane shows the byte order, the dropped low byte of the last word, and the placement of the start and end flags. Bad tags, and unflagged words at position zero, are each followed by a probe word whose loss result differs depending on whether the discarded word changed the reference. This separates a true discard from one that leaks into state. Counts that step by one, jump, and wrap from 7 to 0 tell a correct modulo-8 check apart from an off-by-one or non-wrapping compare. Interleaved streams and a restart in the middle of a packet show that the state is kept per stream. A pair of words at the minimum spacing shows that the serializer hands over without losing a byte.

// File: rtl/mpr_pkg.sv
package mpr_pkg;
  localparam int STREAM_W = 2;
  localparam int LANE_W   = 24;

  typedef struct packed {
    logic                load;
    logic                startPkt;
    logic                lastWord;
    logic [STREAM_W-1:0] streamId;
    logic [LANE_W-1:0]   payload;
  } ctlStrobe_t;
endpackage

// File: rtl/mpr_ctl.sv
module mpr_ctl
  import mpr_pkg::*;
#(
  parameter int NUM_STREAMS   = 4,
  parameter int WORDS_PER_PKT = 63
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   inValid,
  input  logic [31:0]            inWord,
  output ctlStrobe_t             strobe,
  output logic [NUM_STREAMS-1:0] lossPulse,
  output logic [NUM_STREAMS-1:0] ovflPulse
);
  localparam int POS_W = $clog2(WORDS_PER_PKT);
  localparam logic [POS_W-1:0] LAST_POS = POS_W'(WORDS_PER_PKT - 1);

  logic [POS_W-1:0]       posQ   [NUM_STREAMS];
  logic [2:0]             seqQ   [NUM_STREAMS];
  logic [NUM_STREAMS-1:0] refOkQ;

  logic [2:0]          tag;
  logic [2:0]          rxSeq;
  logic                sof;
  logic                ovf;
  logic                tagOk;
  logic [STREAM_W-1:0] sid;
  logic [POS_W-1:0]    curPos;
  logic [2:0]          curSeq;
  logic                curRefOk;
  logic [POS_W-1:0]    effPos;
  logic                accept;
  logic                isLast;
  logic                seqBad;
  logic [NUM_STREAMS-1:0] lossNext;
  logic [NUM_STREAMS-1:0] ovflNext;

  assign tag   = inWord[31:29];
  assign rxSeq = inWord[28:26];
  assign sof   = inWord[25];
  assign ovf   = inWord[24];
  assign tagOk = (tag != 3'd0) && (tag <= 3'(NUM_STREAMS));
  assign sid   = STREAM_W'(tag - 3'd1);

  always_comb begin
    curPos   = '0;
    curSeq   = '0;
    curRefOk = 1'b0;
    for (int i = 0; i < NUM_STREAMS; i++) begin
      if (tagOk && sid == STREAM_W'(i)) begin
        curPos   = posQ[i];
        curSeq   = seqQ[i];
        curRefOk = refOkQ[i];
      end
    end
  end

  assign effPos = sof ? '0 : curPos;
  assign accept = inValid && tagOk && (sof || curPos != '0);
  assign isLast = (effPos == LAST_POS);
  assign seqBad = curRefOk && (rxSeq != curSeq + 3'd1);

  always_comb begin
    strobe.load     = accept;
    strobe.startPkt = (effPos == '0);
    strobe.lastWord = isLast;
    strobe.streamId = sid;
    strobe.payload  = inWord[23:0];
  end

  always_comb begin
    for (int i = 0; i < NUM_STREAMS; i++) begin
      lossNext[i] = accept && (sid == STREAM_W'(i)) && seqBad;
      ovflNext[i] = accept && (sid == STREAM_W'(i)) && ovf;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lossPulse <= '0;
      ovflPulse <= '0;
    end else begin
      lossPulse <= lossNext;
      ovflPulse <= ovflNext;
    end
  end

  for (genvar g = 0; g < NUM_STREAMS; g++) begin : gStream
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        posQ[g]   <= '0;
        seqQ[g]   <= '0;
        refOkQ[g] <= 1'b0;
      end else if (accept && sid == STREAM_W'(g)) begin
        posQ[g]   <= isLast ? '0 : effPos + POS_W'(1);
        seqQ[g]   <= rxSeq;
        refOkQ[g] <= 1'b1;
      end
    end

    AST_POS_HAS_REF: assert property (@(posedge clk) disable iff (!rstN)
      (posQ[g] != '0) |-> refOkQ[g]); // R10
  end

  AST_LOSS_ONEHOT: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(lossPulse)); // R5
  AST_OVFL_FROM_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    (ovflPulse != '0) |-> $past(inValid && inWord[24])); // R6
  AST_BADTAG_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && !tagOk) |=> (lossPulse == '0 && ovflPulse == '0)); // R2
endmodule

// File: rtl/mpr_dp.sv
module mpr_dp
  import mpr_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  ctlStrobe_t          strobe,
  output logic                outValid,
  output logic [7:0]          outByte,
  output logic                outStart,
  output logic                outEnd,
  output logic [STREAM_W-1:0] outStream
);
  logic [1:0]  remain;
  logic [15:0] hold;
  logic        lastFlag;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      remain    <= '0;
      hold      <= '0;
      lastFlag  <= 1'b0;
      outValid  <= 1'b0;
      outByte   <= '0;
      outStart  <= 1'b0;
      outEnd    <= 1'b0;
      outStream <= '0;
    end else if (strobe.load) begin
      outValid  <= 1'b1;
      outByte   <= strobe.payload[23:16];
      outStart  <= strobe.startPkt;
      outEnd    <= 1'b0;
      outStream <= strobe.streamId;
      hold      <= strobe.payload[15:0];
      remain    <= strobe.lastWord ? 2'd1 : 2'd2;
      lastFlag  <= strobe.lastWord;
    end else if (remain != 2'd0) begin
      outValid  <= 1'b1;
      outByte   <= hold[15:8];
      outStart  <= 1'b0;
      outEnd    <= (remain == 2'd1) && lastFlag;
      hold      <= {hold[7:0], 8'd0};
      remain    <= remain - 2'd1;
    end else begin
      outValid  <= 1'b0;
      outStart  <= 1'b0;
      outEnd    <= 1'b0;
    end
  end

  AST_LOAD_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    strobe.load |-> (remain == 2'd0)); // R11
  AST_END_NOT_START: assert property (@(posedge clk) disable iff (!rstN)
    outEnd |-> (outValid && !outStart)); // R8
  AST_START_FROM_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    outStart |-> $past(strobe.load && strobe.startPkt)); // R3
endmodule

// File: rtl/mpkt_reasm.sv
module mpkt_reasm
  import mpr_pkg::*;
#(
  parameter int NUM_STREAMS   = 4,
  parameter int WORDS_PER_PKT = 63
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   inValid,
  input  logic [31:0]            inWord,
  output logic                   outValid,
  output logic [7:0]             outByte,
  output logic                   outStart,
  output logic                   outEnd,
  output logic [STREAM_W-1:0]    outStream,
  output logic [NUM_STREAMS-1:0] lossPulse,
  output logic [NUM_STREAMS-1:0] ovflPulse
);
  ctlStrobe_t strobe;

  mpr_ctl #(
    .NUM_STREAMS  (NUM_STREAMS),
    .WORDS_PER_PKT(WORDS_PER_PKT)
  ) u_ctl (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .inWord   (inWord),
    .strobe   (strobe),
    .lossPulse(lossPulse),
    .ovflPulse(ovflPulse)
  );

  mpr_dp u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .outValid (outValid),
    .outByte  (outByte),
    .outStart (outStart),
    .outEnd   (outEnd),
    .outStream(outStream)
  );

  AST_PULSE_WITH_BYTE: assert property (@(posedge clk) disable iff (!rstN)
    (lossPulse != '0 || ovflPulse != '0) |-> (outValid && $past(inValid))); // R5
endmodule

// File: tb/mpkt_reasm_bench.sv
module mpkt_reasm_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic [31:0] inWord = '0;
  logic        outValid;
  logic [7:0]  outByte;
  logic        outStart;
  logic        outEnd;
  logic [1:0]  outStream;
  logic [3:0]  lossPulse;
  logic [3:0]  ovflPulse;

  int total = 0;
  int bad = 0;

  logic       capV   [3];
  logic [7:0] capB   [3];
  logic       capS   [3];
  logic       capE   [3];
  logic [1:0] capStr [3];
  logic [3:0] capLoss;
  logic [3:0] capOvfl;

  always #(CLK_PERIOD/2) clk = ~clk;

  mpkt_reasm u_mpkt_reasm (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inWord(inWord),
    .outValid(outValid), .outByte(outByte), .outStart(outStart),
    .outEnd(outEnd), .outStream(outStream),
    .lossPulse(lossPulse), .ovflPulse(ovflPulse)
  );

  function automatic logic [31:0] mkWord(int tag, bit sof, bit ovf, int seq,
                                         logic [23:0] pl);
    return {3'(tag), 3'(seq), sof, ovf, pl};
  endfunction

  task automatic check(bit ok, string req, string what, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic grab(int k);
    capV[k]   = outValid;
    capB[k]   = outByte;
    capS[k]   = outStart;
    capE[k]   = outEnd;
    capStr[k] = outStream;
    if (k == 0) begin
      capLoss = lossPulse;
      capOvfl = ovflPulse;
    end
  endtask

  task automatic sendWord(logic [31:0] w);
    @(negedge clk);
    inValid = 1'b1;
    inWord  = w;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      if (k == 0) inValid = 1'b0;
      grab(k);
    end
  endtask

  task automatic expectNothing(string req);
    check(capV[0] == 0 && capV[1] == 0 && capV[2] == 0, req, "no bytes",
          int'(capV[0]) + int'(capV[1]) + int'(capV[2]), 0);
    check(capLoss == 0 && capOvfl == 0, req, "no pulses",
          int'({capLoss, capOvfl}), 0);
  endtask

  task automatic tReset();
    @(negedge clk);
    check(!outValid && !outStart && !outEnd && lossPulse == 0 && ovflPulse == 0,
          "R1", "outputs in reset", int'(outValid), 0);
    rstN = 1'b1;
    @(negedge clk);
    check(!outValid && !outStart && !outEnd && lossPulse == 0 && ovflPulse == 0,
          "R1", "outputs after reset", int'(outValid), 0);
  endtask

  task automatic tBadTag();
    sendWord(mkWord(0, 1, 1, 0, 24'h111111));
    expectNothing("R2");
    sendWord(mkWord(5, 1, 1, 0, 24'h222222));
    expectNothing("R2");
    sendWord(mkWord(7, 1, 0, 0, 24'h333333));
    expectNothing("R2");
    // stream 0 must still sit at position zero: unflagged word discarded
    sendWord(mkWord(1, 0, 0, 1, 24'h444444));
    expectNothing("R2");
  endtask

  task automatic tDiscard();
    sendWord(mkWord(2, 0, 1, 4, 24'hABCDEF));
    expectNothing("R4");
  endtask

  task automatic tSeq();
    sendWord(mkWord(4, 1, 0, 3, 24'h010203));
    check(capLoss == 0, "R5", "first word unchecked", int'(capLoss), 0);
    check(capV[0] && capStr[0] == 2'd3, "R7", "stream number 3", int'(capStr[0]), 3);
    sendWord(mkWord(4, 0, 0, 4, 24'h040506));
    check(capLoss == 0, "R5", "in-order count", int'(capLoss), 0);
    sendWord(mkWord(4, 0, 0, 6, 24'h070809));
    check(capLoss == 4'b1000, "R5", "gap flagged", int'(capLoss), 8);
    check(capV[0], "R5", "pulse with first byte", int'(capV[0]), 1);
    sendWord(mkWord(4, 0, 0, 7, 24'h0A0B0C));
    check(capLoss == 0, "R5", "reference follows received", int'(capLoss), 0);
    sendWord(mkWord(4, 0, 0, 0, 24'h0D0E0F));
    check(capLoss == 0, "R5", "wrap 7 to 0", int'(capLoss), 0);
  endtask

  task automatic tFullPacket();
    int nBytes = 0;
    int nStart = 0;
    int nEnd = 0;
    int endAt = -1;
    int mism = 0;
    int lossSeen = 0;
    for (int w = 0; w < 63; w++) begin
      logic [7:0] b2 = 8'(w);
      logic [7:0] b1 = 8'(w + 64);
      logic [7:0] b0 = 8'(w + 128);
      sendWord(mkWord(3, w == 0, 0, w % 8, {b2, b1, b0}));
      if (capLoss != 0) lossSeen++;
      for (int k = 0; k < 3; k++) begin
        if (capV[k]) begin
          logic [7:0] e = (k == 0) ? b2 : (k == 1) ? b1 : b0;
          if (capB[k] != e || capStr[k] != 2'd2) mism++;
          if (capS[k]) begin
            nStart++;
            if (nBytes != 0) mism++;
          end
          if (capE[k]) begin
            nEnd++;
            endAt = nBytes;
          end
          nBytes++;
        end
      end
      if (w == 62)
        check(!capV[2], "R8", "low byte of last word dropped", int'(capV[2]), 0);
    end
    check(nBytes == 188, "R8", "bytes per packet", nBytes, 188);
    check(nStart == 1 && nEnd == 1, "R8", "one start and one end", nStart + nEnd, 2);
    check(endAt == 187, "R8", "end on byte 187", endAt, 187);
    check(mism == 0, "R7", "byte order and values", mism, 0);
    check(lossSeen == 0, "R5", "no loss on clean packet", lossSeen, 0);
    // position wrapped: unflagged word is discarded, reference untouched
    sendWord(mkWord(3, 0, 1, 3, 24'h555555));
    expectNothing("R9");
    sendWord(mkWord(3, 1, 0, 7, 24'h666666));
    check(capLoss == 0, "R4", "discard left reference at 6", int'(capLoss), 0);
    check(capV[0] && capS[0], "R9", "flagged word restarts packet", int'(capS[0]), 1);
  endtask

  task automatic tOvfl();
    sendWord(mkWord(1, 1, 1, 0, 24'h123456));
    check(capOvfl == 4'b0001, "R6", "overflow pulse stream 0", int'(capOvfl), 1);
    check(capV[0] && capB[0] == 8'h12 && capB[1] == 8'h34 && capB[2] == 8'h56,
          "R7", "byte order", int'(capB[1]), 'h34);
    check(capS[0] && !capS[1], "R3", "start on first byte", int'(capS[0]), 1);
  endtask

  task automatic tInterleave();
    sendWord(mkWord(1, 0, 0, 1, 24'hA1A2A3));
    check(capV[0] && !capS[0] && capStr[0] == 2'd0, "R10", "stream 0 continues",
          int'(capS[0]), 0);
    check(capLoss == 0, "R10", "stream 0 count kept", int'(capLoss), 0);
    sendWord(mkWord(2, 1, 0, 0, 24'hB1B2B3));
    check(capV[0] && capS[0] && capStr[0] == 2'd1, "R10", "stream 1 starts",
          int'(capStr[0]), 1);
    sendWord(mkWord(1, 0, 0, 2, 24'hC1C2C3));
    check(capV[0] && !capS[0] && capB[0] == 8'hC1 && capLoss == 0, "R10",
          "stream 0 unaffected by stream 1", int'(capB[0]), 'hC1);
    sendWord(mkWord(2, 0, 0, 1, 24'hD1D2D3));
    check(capV[0] && !capS[0] && capStr[0] == 2'd1 && capLoss == 0, "R10",
          "stream 1 position kept", int'(capS[0]), 0);
    sendWord(mkWord(1, 1, 0, 3, 24'hE1E2E3));
    check(capV[0] && capS[0] && capLoss == 0, "R3", "mid-packet restart",
          int'(capS[0]), 1);
  endtask

  task automatic tTight();
    @(negedge clk);
    inValid = 1'b1;
    inWord  = mkWord(2, 0, 0, 2, 24'hF1F2F3);
    @(negedge clk);
    inValid = 1'b0;
    grab(0);
    @(negedge clk);
    grab(1);
    @(negedge clk);
    grab(2);
    inValid = 1'b1;
    inWord  = mkWord(2, 0, 0, 3, 24'h919293);
    check(capV[0] && capV[1] && capV[2] && capB[2] == 8'hF3, "R11",
          "first word complete", int'(capB[2]), 'hF3);
    @(negedge clk);
    inValid = 1'b0;
    check(outValid && outByte == 8'h91 && lossPulse == 0, "R11",
          "second word first byte", int'(outByte), 'h91);
    @(negedge clk);
    check(outValid && outByte == 8'h92, "R11", "second word second byte",
          int'(outByte), 'h92);
    @(negedge clk);
    check(outValid && outByte == 8'h93, "R11", "second word third byte",
          int'(outByte), 'h93);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    tReset();
    tBadTag();
    tDiscard();
    tSeq();
    tFullPacket();
    tOvfl();
    tInterleave();
    tTight();
    repeat (4) @(negedge clk);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    total++;
    bad++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule